// File: doc/BRIEF.md
# Atomic Memory Unit with Reservation

This block runs one 32-bit word atomic operation at a time against a single-port word memory. The requester supplies a 5-bit operation code taken from the atomic instruction, a word address and a source operand, then pulses `start_i`. Nine read-modify-write operations share one sequence. The unit reads the word, computes the new value in a separate cycle, writes it back and returns the value the memory held before the operation.

The unit also holds one reservation register for the load-reserved / store-conditional pair. A load-reserved reads the word and records its address. A later store-conditional to that same address writes its operand and reports success. A store-conditional to any other address, or one issued with no valid reservation, reports failure and leaves memory alone. Every memory access uses a request/ready handshake: the request stays up, with stable address, direction and data, until the memory returns ready. Read data is taken in the cycle ready is high.

Top module: `amo_unit`

## Requirements
- R1: The operation code selects the operation as follows: add 00000, swap 00001, load-reserved 00010, store-conditional 00011, xor 00100, or 01000, and 01100, min 10000, max 10100, minu 11000, maxu 11100. Every read-modify-write operation returns the word memory held before it.
- R2: The word written back is the operand for swap, and old+operand, old^operand, old&operand or old|operand for add, xor, and and or.
- R3: min and max write back the smaller or larger of old and operand, compared as two's-complement values. minu and maxu compare them as unsigned values.
- R4: Load-reserved returns the addressed word, writes nothing, marks the reservation valid and records the address.
- R5: Store-conditional with a valid reservation whose address equals its own writes the operand, returns 0 and clears the reservation. A second store-conditional to that address therefore fails.
- R6: Store-conditional with no valid reservation, or with a reservation for a different address, writes nothing and returns 1.
- R7: `done_o` is high for exactly one cycle per accepted operation, and `result_o` is valid in that cycle. Counted in rising edges after the edge that samples `start_i`, with w wait cycles per memory access, `done_o` rises after 3+2w edges for read-modify-write, 1+w for load-reserved and for a successful store-conditional, and 0 for a failed store-conditional.
- R8: A `start_i` seen while `busy_o` is high is ignored. No extra completion occurs and memory is unchanged.
- R9: Reset drives `busy_o`, `done_o` and `mem_req_o` low and invalidates the reservation.
- R10: While `mem_req_o` is high and `mem_ready_i` is low, the request, address, write enable and write data hold steady.
- R11: An operation code outside the R1 list completes after 0 edges with result 0 and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch an operation when idle |
| funct5_i | input | 5 | Operation code |
| addr_i | input | AW | Word address |
| operand_i | input | DW | Source operand |
| busy_o | output | 1 | Operation in progress, including the completion cycle |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DW | Old value, store-conditional status, or 0 |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | DW | Read data, valid with ready |

## Verification
When an operation launches, the bench computes its expected result, the memory word after the operation, and the completion latency from R7 using the memory wait count it has set. It pushes these into a scoreboard queue. A monitor samples on falling edges. It pops an entry when `done_o` is high and compares the result, the word in the bench-owned memory, and the number of rising edges since launch, so a completion one cycle early or late is counted as a failure. Runs with zero and with two wait cycles exercise both latency formulas. A `done_o` with an empty queue is also counted as a failure, which is how an ignored or duplicated start is caught.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'b00000,
        OP_SWAP = 5'b00001,
        OP_LR   = 5'b00010,
        OP_SC   = 5'b00011,
        OP_XOR  = 5'b00100,
        OP_OR   = 5'b01000,
        OP_AND  = 5'b01100,
        OP_MIN  = 5'b10000,
        OP_MAX  = 5'b10100,
        OP_MINU = 5'b11000,
        OP_MAXU = 5'b11100
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_DONE
    } amo_state_e;

    // true for the nine read-compute-write codes
    function automatic logic is_rmw(input logic [4:0] f);
        case (f)
            OP_ADD, OP_SWAP, OP_XOR, OP_OR, OP_AND,
            OP_MIN, OP_MAX, OP_MINU, OP_MAXU: is_rmw = 1'b1;
            default:                          is_rmw = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu #(
    parameter int DW = 32
) (
    input  logic [4:0]    op_i,
    input  logic [DW-1:0] old_i,
    input  logic [DW-1:0] opnd_i,
    output logic [DW-1:0] new_o
);
    import amo_pkg::*;

    logic s_lt;
    logic u_lt;

    always_comb begin
        s_lt = $signed(opnd_i) < $signed(old_i);
        u_lt = opnd_i < old_i;
        case (op_i)
            OP_SWAP: new_o = opnd_i;
            OP_ADD:  new_o = old_i + opnd_i;
            OP_XOR:  new_o = old_i ^ opnd_i;
            OP_AND:  new_o = old_i & opnd_i;
            OP_OR:   new_o = old_i | opnd_i;
            OP_MIN:  new_o = s_lt ? opnd_i : old_i;
            OP_MAX:  new_o = s_lt ? old_i : opnd_i;
            OP_MINU: new_o = u_lt ? opnd_i : old_i;
            OP_MAXU: new_o = u_lt ? old_i : opnd_i;
            default: new_o = old_i;
        endcase
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clr_i,
    input  logic [AW-1:0] set_addr_i,
    input  logic [AW-1:0] chk_addr_i,
    output logic          hit_o
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
    } resv_t;

    resv_t resv_d, resv_q;

    always_comb begin
        resv_d = resv_q;
        if (clr_i) begin
            resv_d.vld = 1'b0;
        end
        if (set_i) begin
            resv_d.vld  = 1'b1;
            resv_d.addr = set_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end

    assign hit_o = resv_q.vld && (resv_q.addr == chk_addr_i);
endmodule

// File: rtl/amo_seq.sv
module amo_seq #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [4:0]    funct5_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] operand_i,
    input  logic          resv_hit_i,
    input  logic [DW-1:0] alu_new_i,
    output logic [4:0]    op_o,
    output logic [DW-1:0] old_o,
    output logic [DW-1:0] opnd_o,
    output logic          resv_set_o,
    output logic          resv_clr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] result_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ready_i,
    input  logic [DW-1:0] mem_rdata_i
);
    import amo_pkg::*;

    localparam logic [DW-1:0] SC_FAIL = DW'(1);

    typedef struct packed {
        amo_state_e    state;
        logic [4:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] opnd;
        logic [DW-1:0] res;
        logic [DW-1:0] wdata;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        resv_set_o = 1'b0;
        resv_clr_o = 1'b0;
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.op   = funct5_i;
                    s_d.addr = addr_i;
                    s_d.opnd = operand_i;
                    if (is_rmw(funct5_i) || funct5_i == OP_LR) begin
                        s_d.state = ST_READ;
                    end else if (funct5_i == OP_SC) begin
                        if (resv_hit_i) begin
                            s_d.wdata = operand_i;
                            s_d.res   = '0;
                            s_d.state = ST_WRITE;
                        end else begin
                            s_d.res   = SC_FAIL;
                            s_d.state = ST_DONE;
                        end
                    end else begin
                        s_d.res   = '0;
                        s_d.state = ST_DONE;
                    end
                end
            end
            ST_READ: begin
                mem_req_o = 1'b1;
                if (mem_ready_i) begin
                    s_d.res = mem_rdata_i;
                    if (s_q.op == OP_LR) begin
                        resv_set_o = 1'b1;
                        s_d.state  = ST_DONE;
                    end else begin
                        s_d.state  = ST_CALC;
                    end
                end
            end
            ST_CALC: begin
                s_d.wdata = alu_new_i;
                s_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                mem_req_o = 1'b1;
                mem_we_o  = 1'b1;
                if (mem_ready_i) begin
                    if (s_q.op == OP_SC) begin
                        resv_clr_o = 1'b1;
                    end
                    s_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                s_d.state = ST_IDLE;
            end
            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign op_o        = s_q.op;
    assign old_o       = s_q.res;
    assign opnd_o      = s_q.opnd;
    assign busy_o      = (s_q.state != ST_IDLE);
    assign done_o      = (s_q.state == ST_DONE);
    assign result_o    = s_q.res;
    assign mem_addr_o  = s_q.addr;
    assign mem_wdata_o = s_q.wdata;
endmodule

// File: rtl/amo_unit.sv
module amo_unit #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [4:0]    funct5_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] operand_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] result_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ready_i,
    input  logic [DW-1:0] mem_rdata_i
);
    logic [4:0]    op_w;
    logic [DW-1:0] old_w;
    logic [DW-1:0] opnd_w;
    logic [DW-1:0] new_w;
    logic          set_w;
    logic          clr_w;
    logic          hit_w;

    amo_alu #(.DW(DW)) u_alu (
        .op_i   (op_w),
        .old_i  (old_w),
        .opnd_i (opnd_w),
        .new_o  (new_w)
    );

    amo_resv #(.AW(AW)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_w),
        .clr_i      (clr_w),
        .set_addr_i (mem_addr_o),
        .chk_addr_i (addr_i),
        .hit_o      (hit_w)
    );

    amo_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .funct5_i    (funct5_i),
        .addr_i      (addr_i),
        .operand_i   (operand_i),
        .resv_hit_i  (hit_w),
        .alu_new_i   (new_w),
        .op_o        (op_w),
        .old_o       (old_w),
        .opnd_o      (opnd_w),
        .resv_set_o  (set_w),
        .resv_clr_o  (clr_w),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .result_o    (result_o),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ready_i (mem_ready_i),
        .mem_rdata_i (mem_rdata_i)
    );
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          mem_ready_i
);
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o) || $past(start_i));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !done_o);

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_we_o)
            && $stable(mem_addr_o) && $stable(mem_wdata_o));

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && busy_o && !done_o |=> busy_o && $stable(mem_addr_o));
endmodule

bind amo_unit amo_unit_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ready_i (mem_ready_i)
);

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
    import amo_pkg::*;

    localparam int DW    = 32;
    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    funct5 = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] opnd = '0;
    logic          busy, done, mem_req, mem_we, mem_ready;
    logic [DW-1:0] result, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    always #2.5 clk = ~clk;

    amo_unit #(.DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .funct5_i(funct5),
        .addr_i(addr), .operand_i(opnd), .busy_o(busy), .done_o(done),
        .result_o(result), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
    );

    // bench-owned memory with programmable wait cycles
    logic [DW-1:0] mem [WORDS];
    int wait_n = 0;
    int wcnt = 0;
    int cyc = 0;
    assign mem_ready = mem_req && (wcnt == wait_n);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else                       wcnt <= 0;
        if (mem_req && mem_we && mem_ready) mem[mem_addr] <= mem_wdata;
    end

    typedef struct {
        string         req;
        logic [DW-1:0] res;
        int            a;
        logic [DW-1:0] memv;
        int            lat;
        int            t0;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    logic [DW-1:0] xmem [WORDS];
    logic rv_vld = 1'b0;
    int   rv_addr = 0;
    bit   finished = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk("R8", "unexpected done", 32'(done), 32'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(it.req, "result", result, it.res);
                chk(it.req, "memory word", mem[it.a], it.memv);
                chk("R7", "latency", 32'(cyc - it.t0), 32'(it.lat));
            end
        end
    end

    task automatic launch(input logic [4:0] f, input int a, input logic [DW-1:0] v,
                          input string req, input bit intrude);
        item_t it;
        logic [DW-1:0] old, nv, res;
        bit wr;
        int lat;
        old = xmem[a];
        wr  = 1'b0;
        res = old;
        nv  = old;
        lat = 3 + 2 * wait_n;
        case (f)
            OP_ADD:  begin nv = old + v; wr = 1; end
            OP_SWAP: begin nv = v; wr = 1; end
            OP_XOR:  begin nv = old ^ v; wr = 1; end
            OP_AND:  begin nv = old & v; wr = 1; end
            OP_OR:   begin nv = old | v; wr = 1; end
            OP_MIN:  begin nv = ($signed(v) < $signed(old)) ? v : old; wr = 1; end
            OP_MAX:  begin nv = ($signed(v) > $signed(old)) ? v : old; wr = 1; end
            OP_MINU: begin nv = (v < old) ? v : old; wr = 1; end
            OP_MAXU: begin nv = (v > old) ? v : old; wr = 1; end
            OP_LR:   begin lat = 1 + wait_n; rv_vld = 1; rv_addr = a; end
            OP_SC: begin
                if (rv_vld && rv_addr == a) begin
                    nv = v; wr = 1; res = '0; lat = 1 + wait_n; rv_vld = 0;
                end else begin
                    res = 32'd1; lat = 0;
                end
            end
            default: begin res = '0; lat = 0; end
        endcase
        if (wr) xmem[a] = nv;
        @(negedge clk);
        it.req = req; it.res = res; it.a = a; it.memv = xmem[a];
        it.lat = lat; it.t0 = cyc + 1;
        sb.push_back(it);
        funct5 = f; addr = AW'(a); opnd = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intrude && busy) begin
            // R8: a second start while busy must be dropped
            funct5 = OP_SWAP; addr = AW'(a ^ 1); opnd = 32'hDEAD_BEEF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i]  = 32'h1000 * i + 32'h11;
            xmem[i] = 32'h1000 * i + 32'h11;
        end
        repeat (3) @(negedge clk);
        // R9: reset state at the ports
        chk("R9", "busy at reset", 32'(busy), 0);
        chk("R9", "done at reset", 32'(done), 0);
        chk("R9", "req at reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int w = 0; w < 3; w += 2) begin
            wait_n = w;
            // R1 R2: basic read-modify-write family
            launch(OP_ADD,  1, 32'h0000_0005, "R2", 0);
            launch(OP_SWAP, 2, 32'hCAFE_F00D, "R2", 0);
            launch(OP_XOR,  3, 32'hFFFF_0000, "R2", 0);
            launch(OP_AND,  4, 32'h0000_F0F0, "R2", 0);
            launch(OP_OR,   5, 32'h8000_0001, "R1", 0);
            // R3: signed and unsigned compares
            launch(OP_SWAP, 6, 32'hFFFF_FFF0, "R1", 0);
            launch(OP_MIN,  6, 32'h0000_0004, "R3", 0);
            launch(OP_MAX,  6, 32'h0000_0004, "R3", 0);
            launch(OP_SWAP, 6, 32'hFFFF_FFF0, "R1", 0);
            launch(OP_MINU, 6, 32'h0000_0004, "R3", 0);
            launch(OP_MAXU, 6, 32'h0000_0004, "R3", 0);
            launch(OP_MAXU, 6, 32'h0000_0004, "R3", 0);
            // R4 R5 R6: reservation pair
            launch(OP_SC,   7, 32'h1234_5678, "R6", 0);
            launch(OP_LR,   7, 32'h0,         "R4", 0);
            launch(OP_SC,   8, 32'h1234_5678, "R6", 0);
            launch(OP_SC,   7, 32'h1234_5678, "R5", 0);
            launch(OP_SC,   7, 32'h5555_AAAA, "R5", 0);
            launch(OP_LR,   9, 32'h0,         "R4", 0);
            launch(OP_LR,  10, 32'h0,         "R4", 0);
            launch(OP_SC,   9, 32'h7777_0000, "R6", 0);
            launch(OP_SC,  10, 32'h7777_0001, "R5", 0);
            // R11: undefined code
            launch(5'b00101, 11, 32'h9999_9999, "R11", 0);
            launch(5'b11111, 12, 32'h9999_9999, "R11", 0);
            // R8: start while busy
            launch(OP_ADD, 12, 32'h0000_0100, "R8", 1);
            chk("R8", "neighbour word", mem[13], xmem[13]);
        end

        // R9: reset drops the reservation
        wait_n = 0;
        launch(OP_LR, 14, 32'h0, "R4", 0);
        @(negedge clk);
        rst_n = 1'b0;
        rv_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        launch(OP_SC, 14, 32'hABCD_0000, "R9", 0);
        repeat (3) @(negedge clk);
        chk("R8", "scoreboard drained", 32'(sb.size()), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule